// File: doc/BRIEF.md
# Compare-Match Virtual Timer

This block keeps a 64-bit up-counter that advances on a tick-enable input, and a 64-bit compare value. When the count is at or past the compare value, a status bit is set. If the timer is enabled and not masked, a level interrupt is raised. Software reads and writes four 64-bit registers through a simple one-cycle port:

- the count;
- the compare value;
- a control word holding enable, mask and status;
- a frequency word that only stores what is written.

A typical use is a periodic interrupt. At each interrupt, software writes a new compare value: the current count plus one period. That write drops the interrupt until the counter catches up again. The tick input sets the counting rate, so the frequency word is information for software only.

Top module: `cmt_vtimer`

## Requirements
- R1: After reset:
  - count, compare and rdata are 0 and irq is low;
  - the stored enable and mask bits are 0;
  - the frequency word reads 0x3B9ACA0;
  - control reads 4, because the status bit is set when the count (0) equals the compare value (0).
- R2: The count increases by exactly one at each clock edge where tick is high. It holds its value when tick is low, whatever the other inputs do.
- R3: The status bit (control bit 2) reads 1 exactly when count >= compare, compared as 64-bit unsigned values. This includes the case where they are equal.
- R4: irq is a register that equals enable & status & ~mask as sampled one clock edge earlier.
- R5: While the mask bit (control bit 1) is 1, irq stays low even when the status bit is 1.
- R6: While the enable bit (control bit 0) is 0, irq stays low.
- R7: Writing a compare value above the current count clears the status bit at once and drops irq one edge later. irq rises again once the count reaches the new value.
- R8: The frequency word returns the last value written. Its contents do not change the counting rate.
- R9: Writes to the count offset are ignored. Writes to control change only bits 0 and 1, and a later read shows no trace of other written bits.
- R10: Register offsets are 0x00 count, 0x08 compare, 0x10 control and 0x18 frequency. A read request loads rdata at the next clock edge. rdata holds its value until the next read request.
- R11: An address with any of its low three bits set selects no register. A read of such an address returns 0, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-advance enable, one increment per cycle when high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W (5) | Byte offset of the register |
| wdata | input | DATA_W (64) | Write data |
| rdata | output | DATA_W (64) | Registered read data |
| irq | output | 1 | Registered level interrupt |

## Verification
The table of vectors is run with tick low, so the count stays at zero. It covers:
- compare values below, equal to and far above the count, with the top value of the range showing that the comparison is unsigned;
- each pairing of the enable and mask bits, which separates the three interrupt gates;
- writes to read-only fields and to misaligned offsets.

The directed tests then run the counter with tick held high, with tick alternating, and after a frequency write, to tell gated counting apart from free running. Stepping across a compare boundary one tick at a time shows the status bit setting on equality, and the interrupt following exactly one edge later. A rearm write, a read-hold check and a reset taken mid-run complete the set.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

  localparam int unsigned SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_COUNT = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_CTL   = 2'd2,
    SEL_FREQ  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_MASK_BIT = 1;
  localparam int unsigned CTL_STAT_BIT = 2;

  typedef struct packed {
    logic mask;
    logic en;
  } ctl_t;

endpackage

// File: rtl/cmt_counter.sv
module cmt_counter #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [DATA_W-1:0] count_o
);

  localparam logic [DATA_W-1:0] STEP = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= count_q + STEP;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/cmt_match.sv
module cmt_match #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] count_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  cmt_pkg::ctl_t     ctl_i,
  output logic              istatus_o,
  output logic              irq_o
);

  logic met;
  logic irq_q;

  // unsigned magnitude compare; equality counts as met
  assign met = (count_i >= cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= ctl_i.en & met & ~ctl_i.mask;
    end
  end

  assign istatus_o = met;
  assign irq_o     = irq_q;

endmodule

// File: rtl/cmt_regs.sv
module cmt_regs #(
  parameter int unsigned       DATA_W   = 64,
  parameter int unsigned       ADDR_W   = 5,
  parameter logic [DATA_W-1:0] FREQ_RST = 64'd62500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count_i,
  input  logic              istatus_i,
  output logic [DATA_W-1:0] cmp_o,
  output cmt_pkg::ctl_t     ctl_o,
  output logic [DATA_W-1:0] rdata_o
);
  import cmt_pkg::*;

  localparam int unsigned LSB = $clog2(DATA_W / 8);
  localparam int unsigned TOP = LSB + SEL_W;

  logic [DATA_W-1:0] cmp_q;
  logic [DATA_W-1:0] freq_q;
  logic [DATA_W-1:0] rdata_q;
  ctl_t              ctl_q;
  logic              addr_ok;
  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;

  // aligned word inside the four-register window
  assign addr_ok = (addr[LSB-1:0] == '0) && ((addr >> TOP) == '0);
  assign sel     = reg_sel_e'(addr[LSB +: SEL_W]);

  always_comb begin
    rd_mux = '0;
    if (addr_ok) begin
      case (sel)
        SEL_COUNT: rd_mux = count_i;
        SEL_CMP:   rd_mux = cmp_q;
        SEL_CTL: begin
          rd_mux[CTL_EN_BIT]   = ctl_q.en;
          rd_mux[CTL_MASK_BIT] = ctl_q.mask;
          rd_mux[CTL_STAT_BIT] = istatus_i;
        end
        SEL_FREQ:  rd_mux = freq_q;
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q   <= '0;
      freq_q  <= FREQ_RST;
      ctl_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && addr_ok) begin
        case (sel)
          SEL_CMP:  cmp_q  <= wdata;
          SEL_CTL: begin
            ctl_q.en   <= wdata[CTL_EN_BIT];
            ctl_q.mask <= wdata[CTL_MASK_BIT];
          end
          SEL_FREQ: freq_q <= wdata;
          default:  ;
        endcase
      end
      if (rd_en) begin
        rdata_q <= rd_mux;
      end
    end
  end

  assign cmp_o   = cmp_q;
  assign ctl_o   = ctl_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/cmt_vtimer.sv
module cmt_vtimer #(
  parameter int unsigned       DATA_W   = 64,
  parameter int unsigned       ADDR_W   = 5,
  parameter logic [DATA_W-1:0] FREQ_RST = 64'd62500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic [DATA_W-1:0] count_w;
  logic [DATA_W-1:0] cmp_w;
  cmt_pkg::ctl_t     ctl_w;
  logic              istatus_w;
  logic              en_w;
  logic              mask_w;

  assign en_w   = ctl_w.en;
  assign mask_w = ctl_w.mask;

  cmt_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .count_o (count_w)
  );

  cmt_match #(.DATA_W(DATA_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .count_i   (count_w),
    .cmp_i     (cmp_w),
    .ctl_i     (ctl_w),
    .istatus_o (istatus_w),
    .irq_o     (irq)
  );

  cmt_regs #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .FREQ_RST (FREQ_RST)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .count_i   (count_w),
    .istatus_i (istatus_w),
    .cmp_o     (cmp_w),
    .ctl_o     (ctl_w),
    .rdata_o   (rdata)
  );

endmodule

// File: rtl/cmt_vtimer_chk.sv
module cmt_vtimer_chk #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] cmp,
  input logic              en,
  input logic              mask,
  input logic              istatus
);

  localparam logic [DATA_W-1:0] STEP    = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] CMP_OFF = ADDR_W'(8);

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> (count == $past(count) + STEP));

  p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));

  p_irq_set_r4: assert property (@(posedge clk) disable iff (rst)
    (en && !mask && istatus) |=> irq);

  p_mask_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    mask |=> !irq);

  p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);

  p_rearm_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CMP_OFF && wdata > count && !tick) |=> (!istatus && cmp == $past(wdata)));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  p_bad_addr_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr[2:0] != 3'd0) |=> (rdata == '0));

endmodule

bind cmt_vtimer cmt_vtimer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .irq     (irq),
  .count   (count_w),
  .cmp     (cmp_w),
  .en      (en_w),
  .mask    (mask_w),
  .istatus (istatus_w)
);

// File: tb/sim_cmt_vtimer.sv
`timescale 1ns/1ps
module sim_cmt_vtimer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmt_vtimer u0 (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  op;   // 1 write, 2 read
    logic [4:0]  addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 29;
  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 5'h00, 64'd0, 64'd0, 1'b0, 4'd1},          // R1 count
    '{2'd2, 5'h08, 64'd0, 64'd0, 1'b0, 4'd1},          // R1 compare
    '{2'd2, 5'h10, 64'd0, 64'd4, 1'b0, 4'd1},          // R1 control
    '{2'd2, 5'h18, 64'd0, 64'h3B9ACA0, 1'b0, 4'd1},    // R1 frequency
    '{2'd1, 5'h18, 64'h1234, 64'd0, 1'b0, 4'd8},       // R8
    '{2'd2, 5'h18, 64'd0, 64'h1234, 1'b0, 4'd8},       // R8
    '{2'd1, 5'h00, 64'hFFFF, 64'd0, 1'b0, 4'd9},       // R9
    '{2'd2, 5'h00, 64'd0, 64'd0, 1'b0, 4'd9},          // R9
    '{2'd1, 5'h10, 64'hFFFF_FFFF_FFFF_FFFC, 64'd0, 1'b0, 4'd9}, // R9
    '{2'd2, 5'h10, 64'd0, 64'd4, 1'b0, 4'd9},          // R9
    '{2'd1, 5'h0B, 64'h77, 64'd0, 1'b0, 4'd11},        // R11
    '{2'd2, 5'h08, 64'd0, 64'd0, 1'b0, 4'd11},         // R11
    '{2'd2, 5'h0B, 64'd0, 64'd0, 1'b0, 4'd11},         // R11
    '{2'd1, 5'h08, 64'd5, 64'd0, 1'b0, 4'd3},          // R3
    '{2'd2, 5'h10, 64'd0, 64'd0, 1'b0, 4'd3},          // R3
    '{2'd1, 5'h08, ALL1, 64'd0, 1'b0, 4'd3},           // R3
    '{2'd2, 5'h10, 64'd0, 64'd0, 1'b0, 4'd3},          // R3 unsigned
    '{2'd2, 5'h08, 64'd0, ALL1, 1'b0, 4'd10},          // R10
    '{2'd1, 5'h10, 64'd3, 64'd0, 1'b0, 4'd5},          // R5
    '{2'd1, 5'h08, 64'd0, 64'd0, 1'b0, 4'd5},          // R5
    '{2'd2, 5'h10, 64'd0, 64'd7, 1'b0, 4'd5},          // R5
    '{2'd1, 5'h10, 64'd1, 64'd0, 1'b1, 4'd4},          // R4
    '{2'd2, 5'h10, 64'd0, 64'd5, 1'b1, 4'd4},          // R4
    '{2'd1, 5'h08, 64'd9, 64'd0, 1'b0, 4'd7},          // R7
    '{2'd2, 5'h10, 64'd0, 64'd1, 1'b0, 4'd7},          // R7
    '{2'd1, 5'h08, 64'd0, 64'd0, 1'b1, 4'd4},          // R4
    '{2'd1, 5'h10, 64'd6, 64'd0, 1'b0, 4'd6},          // R6
    '{2'd1, 5'h10, 64'd4, 64'd0, 1'b0, 4'd6},          // R6
    '{2'd2, 5'h10, 64'd0, 64'd4, 1'b0, 4'd6}           // R6
  };

  task automatic check(input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // one access, then one idle edge; outputs sampled at the following negedge
  task automatic access(input logic w, input logic [4:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = w; rd_en = ~w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL R2 watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(1, "irq after reset", {63'd0, irq}, 64'd0);     // R1
    check(1, "rdata after reset", rdata, 64'd0);          // R1

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].op == 2'd1, VEC[i].addr, VEC[i].data);
      if (VEC[i].op == 2'd2)
        check(int'(VEC[i].req), "vector read", rdata, VEC[i].exp);
      check(int'(VEC[i].req), "vector irq", {63'd0, irq}, {63'd0, VEC[i].irq});
    end

    // R2: steady ticking
    run_ticks(10);
    access(1'b0, 5'h00, 64'd0);
    check(2, "count after 10 ticks", rdata, 64'd10);

    // R2: alternating tick, three of six cycles high
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tick = (i % 2) == 1;
      @(posedge clk);
    end
    @(negedge clk);
    tick = 1'b0;
    access(1'b0, 5'h00, 64'd0);
    check(2, "count after alternating ticks", rdata, 64'd13);

    // R8: frequency write leaves rate unchanged
    access(1'b1, 5'h18, 64'd1);
    run_ticks(5);
    access(1'b0, 5'h00, 64'd0);
    check(8, "count after freq write", rdata, 64'd18);

    // R7 / R3 / R4: arm at 25, step across the boundary
    access(1'b1, 5'h08, 64'd25);
    access(1'b1, 5'h10, 64'd1);
    check(7, "irq before match", {63'd0, irq}, 64'd0);
    run_ticks(6);
    access(1'b0, 5'h10, 64'd0);
    check(3, "status one below compare", rdata, 64'd1);
    @(negedge clk);
    tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
    check(4, "irq same edge as match", {63'd0, irq}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check(4, "irq one edge after match", {63'd0, irq}, 64'd1);
    access(1'b0, 5'h10, 64'd0);
    check(3, "status at equality", rdata, 64'd5);

    // R7: rearm one period ahead
    access(1'b1, 5'h08, 64'd35);
    check(7, "irq after rearm", {63'd0, irq}, 64'd0);
    run_ticks(10);
    check(7, "irq at edge count hits 35", {63'd0, irq}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    check(7, "irq after second match", {63'd0, irq}, 64'd1);

    // R10: rdata holds while count moves
    access(1'b0, 5'h00, 64'd0);
    check(10, "count read", rdata, 64'd35);
    run_ticks(3);
    check(10, "rdata held", rdata, 64'd35);

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(1, "irq after mid reset", {63'd0, irq}, 64'd0);
    check(1, "rdata after mid reset", rdata, 64'd0);
    access(1'b0, 5'h00, 64'd0);
    check(1, "count after mid reset", rdata, 64'd0);
    access(1'b0, 5'h18, 64'd0);
    check(1, "freq after mid reset", rdata, 64'h3B9ACA0);
    access(1'b0, 5'h10, 64'd0);
    check(1, "control after mid reset", rdata, 64'd4);

    report();
  end

endmodule